// File: doc/BRIEF.md
# Departure Slot Reorder Stage

This stage sits at the output side of a time-slotted packet buffer in which every cell's departure slot is fixed when the cell arrives. During the frame before a cell's departure frame, the bank read logic returns that frame's cells. They arrive in bank order, not in departure order. Each cell carries the departure timestamp that was stored with it. The stage files each returned cell into a per-frame staging area at the position given by that timestamp. During the following frame it sends out exactly one position per clock, so every cell leaves in the slot equal to its timestamp.

Cells that took the short path around the banks are presented on a bypass input in the very slot they must leave. The stage merges them into the output stream. There are two staging areas, each one frame in size. They take turns: while one drains to the output, the other fills from read returns for the next frame. A position that holds no cell and receives no bypass cell produces an idle slot. Read returns that cannot be placed are discarded and flagged. A bank cell and a bypass cell that claim the same slot are also flagged.

The slot clock is a free-running counter that starts at zero when reset is released. One slot passes per clock. A frame is SLOTS consecutive slots, and SLOTS must be a power of two. A timestamp splits into a frame number (the upper TS_W-log2(SLOTS) bits) and a position within the frame (the lower log2(SLOTS) bits).

Top module: `depart_reorder`

## Requirements
- R1: While rst_ni is low, out_valid_o, out_data_o, out_slot_o, collide_o and drop_o are all zero and both staging areas are empty. As a result, the first slots after reset are idle.
- R2: Every clock after reset produces one output slot. out_slot_o is 0 for the first slot and increases by one per clock, wrapping at 2^TS_W. In the cycle after clock edge n (counted from 0 after reset release), out_slot_o shows slot n.
- R3: A read return is accepted when its timestamp's frame field (rd_ts_i[TS_W-1:log2(SLOTS)]) equals the current frame plus one, modulo the field width. An accepted cell is emitted with out_valid_o high and its data in the output slot whose number equals its timestamp. This holds for any arrival order within the frame, and across frame-number wraparound.
- R4: A slot with neither a stored cell nor a bypass cell is emitted with out_valid_o low and out_data_o zero.
- R5: A bypass cell presented while the slot counter is at slot s is emitted as output slot s when no stored cell claims s.
- R6: When a stored cell and a bypass cell both claim slot s, the stored cell's data is emitted and collide_o is high for output slot s only.
- R7: A read return whose timestamp frame is not the next frame is discarded. drop_o is high in the cycle after it is presented, and the cell never appears on the output.
- R8: A read return aimed at a position that already holds a cell for the same frame is discarded and raises drop_o. The cell stored first is kept and emitted.
- R9: Sending a cell out frees its position, so the cell is not emitted again when that staging area is reused two frames later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock, one slot per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_valid_i | input | 1 | Read return present |
| rd_data_i | input | DATA_W | Read return cell data |
| rd_ts_i | input | TS_W | Stored departure timestamp of the read return |
| byp_valid_i | input | 1 | Bypass cell due in the current slot |
| byp_data_i | input | DATA_W | Bypass cell data |
| out_valid_o | output | 1 | Output slot carries a cell |
| out_data_o | output | DATA_W | Output cell data, zero when idle |
| out_slot_o | output | TS_W | Slot number of the current output |
| collide_o | output | 1 | Stored and bypass cell claimed this slot |
| drop_o | output | 1 | A read return was discarded on the previous clock |

## Verification
The main function is exercised in three ways. A full frame is returned in reverse order, which shows whether placement follows the timestamp or the arrival order. A sparse frame is returned into a staging area that was full two frames earlier, which separates idle slots from stale cells that were never freed. A frame is also returned across the frame-number wrap, which catches an acceptance test that fails to wrap. Frames that mix bypass and stored cells distinguish a pure bypass slot from a shared one. Read returns aimed at the current frame, at a frame two ahead, and twice at the same position separate the three rejection cases from a normal store.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_BANK = 2'd1,
    SRC_BYP  = 2'd2
  } src_e;
endpackage

// File: rtl/dr_slot_timer.sv
module dr_slot_timer #(
  parameter int TS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] now_o
);
  logic [TS_W-1:0] now_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + 1'b1;
  end

  assign now_o = now_q;
endmodule

// File: rtl/dr_stage_buf.sv
module dr_stage_buf #(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 16,
  parameter int TS_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TS_W-1:0]   now_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [TS_W-1:0]   rd_ts_i,
  output logic              drain_valid_o,
  output logic [DATA_W-1:0] drain_data_o,
  output logic              drop_o
);
  localparam int IDX_W   = $clog2(SLOTS);
  localparam int FR_W    = TS_W - IDX_W;
  localparam int ENTRIES = 2 * SLOTS;
  localparam int POS_W   = IDX_W + 1;
  localparam logic [FR_W-1:0] FR_ONE = 1;

  logic [FR_W-1:0]  now_fr, ts_fr, nxt_fr;
  logic [IDX_W-1:0] now_idx, ts_idx;
  logic [POS_W-1:0] wr_pos, dr_pos;
  logic             frame_ok, wr_ok;

  logic [ENTRIES-1:0] occ_q, occ_d;
  logic [DATA_W-1:0]  mem_q [ENTRIES];
  logic               drop_q;

  assign now_fr  = now_i[TS_W-1:IDX_W];
  assign now_idx = now_i[IDX_W-1:0];
  assign ts_fr   = rd_ts_i[TS_W-1:IDX_W];
  assign ts_idx  = rd_ts_i[IDX_W-1:0];
  assign nxt_fr  = now_fr + FR_ONE;

  // staging area chosen by frame parity: fill and drain never share one
  assign wr_pos   = {ts_fr[0], ts_idx};
  assign dr_pos   = {now_fr[0], now_idx};
  assign frame_ok = (ts_fr == nxt_fr);
  assign wr_ok    = rd_valid_i && frame_ok && !occ_q[wr_pos];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign occ_d[e] = (wr_ok && wr_pos == POS_W'(e)) ? 1'b1 :
                      (dr_pos == POS_W'(e))           ? 1'b0 : occ_q[e];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      occ_q  <= occ_d;
      drop_q <= rd_valid_i && !wr_ok;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_pos] <= rd_data_i;
  end

  assign drain_valid_o = occ_q[dr_pos];
  assign drain_data_o  = mem_q[dr_pos];
  assign drop_o        = drop_q;

  assert_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> occ_q[$past(wr_pos)]);

  assert_free_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_valid_o |=> !occ_q[$past(dr_pos)]);
endmodule

// File: rtl/dr_out_merge.sv
module dr_out_merge #(
  parameter int DATA_W = 16,
  parameter int TS_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TS_W-1:0]   now_i,
  input  logic              drain_valid_i,
  input  logic [DATA_W-1:0] drain_data_i,
  input  logic              byp_valid_i,
  input  logic [DATA_W-1:0] byp_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [TS_W-1:0]   out_slot_o,
  output logic              collide_o
);
  import dr_pkg::*;

  src_e              src;
  logic [DATA_W-1:0] sel_data;
  logic              valid_q, coll_q, run_q;
  logic [DATA_W-1:0] data_q;
  logic [TS_W-1:0]   slot_q;

  // stored cell has priority over bypass
  always_comb begin
    if (drain_valid_i)    src = SRC_BANK;
    else if (byp_valid_i) src = SRC_BYP;
    else                  src = SRC_IDLE;
  end

  always_comb begin
    case (src)
      SRC_BANK: sel_data = drain_data_i;
      SRC_BYP:  sel_data = byp_data_i;
      default:  sel_data = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      slot_q  <= '0;
      coll_q  <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      valid_q <= (src != SRC_IDLE);
      data_q  <= sel_data;
      slot_q  <= now_i;
      coll_q  <= drain_valid_i && byp_valid_i;
      run_q   <= 1'b1;
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;
  assign out_slot_o  = slot_q;
  assign collide_o   = coll_q;

  assert_slot_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> out_slot_o == TS_W'($past(out_slot_o) + 1'b1));

  assert_collide_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide_o |-> out_valid_o);
endmodule

// File: rtl/depart_reorder.sv
module depart_reorder #(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 16,
  parameter int TS_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [TS_W-1:0]   rd_ts_i,
  input  logic              byp_valid_i,
  input  logic [DATA_W-1:0] byp_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [TS_W-1:0]   out_slot_o,
  output logic              collide_o,
  output logic              drop_o
);
  logic [TS_W-1:0]   now;
  logic              drain_valid;
  logic [DATA_W-1:0] drain_data;

  dr_slot_timer #(.TS_W(TS_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .now_o  (now)
  );

  dr_stage_buf #(.SLOTS(SLOTS), .DATA_W(DATA_W), .TS_W(TS_W)) u_buf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .now_i         (now),
    .rd_valid_i    (rd_valid_i),
    .rd_data_i     (rd_data_i),
    .rd_ts_i       (rd_ts_i),
    .drain_valid_o (drain_valid),
    .drain_data_o  (drain_data),
    .drop_o        (drop_o)
  );

  dr_out_merge #(.DATA_W(DATA_W), .TS_W(TS_W)) u_merge (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .now_i         (now),
    .drain_valid_i (drain_valid),
    .drain_data_i  (drain_data),
    .byp_valid_i   (byp_valid_i),
    .byp_data_i    (byp_data_i),
    .out_valid_o   (out_valid_o),
    .out_data_o    (out_data_o),
    .out_slot_o    (out_slot_o),
    .collide_o     (collide_o)
  );
endmodule

// File: tb/depart_reorder_test.sv
module depart_reorder_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 4;
  localparam int DW = 16;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic [TW-1:0] rd_ts = '0;
  logic byp_valid = 1'b0;
  logic [DW-1:0] byp_data = '0;
  logic out_valid, collide, drop;
  logic [DW-1:0] out_data;
  logic [TW-1:0] out_slot;

  int n_checks = 0;
  int n_fail = 0;
  int now = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  depart_reorder #(.SLOTS(SLOTS), .DATA_W(DW), .TS_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .rd_ts_i(rd_ts),
    .byp_valid_i(byp_valid), .byp_data_i(byp_data),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_slot_o(out_slot),
    .collide_o(collide), .drop_o(drop)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at slot %0d: actual %0h expected %0h", req, now - 1, act, exp);
    end
  endtask

  // one clock: inputs apply at the next edge, outputs then show slot now-1
  task automatic step(input logic rv, input int rd, input int rt,
                      input logic bv, input int bd);
    rd_valid = rv; rd_data = DW'(rd); rd_ts = TW'(rt);
    byp_valid = bv; byp_data = DW'(bd);
    @(posedge clk); #1;
    now++;
    rd_valid = 1'b0; byp_valid = 1'b0;
  endtask

  task automatic idle(); step(1'b0, 0, 0, 1'b0, 0); endtask

  task automatic align();
    while (now % SLOTS != 0) idle();
  endtask

  task automatic t_reset();
    chk("R1 valid", out_valid, 0);
    chk("R1 slot", out_slot, 0);
    chk("R1 collide", collide, 0);
    chk("R1 drop", drop, 0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    for (int i = 0; i < SLOTS; i++) begin
      idle();
      chk("R1 empty after reset", out_valid, 0);
      chk("R2 slot number", out_slot, (now - 1) & 255);
    end
  endtask

  task automatic t_reverse();
    int f;
    align();
    f = now / SLOTS + 1;
    for (int i = 0; i < SLOTS; i++) begin
      step(1'b1, 16'hA000 + ((f*SLOTS + SLOTS-1-i) & 255), f*SLOTS + SLOTS-1-i, 1'b0, 0);
      chk("R3 accepted", drop, 0);
    end
    for (int i = 0; i < SLOTS; i++) begin
      idle();
      chk("R2 slot number", out_slot, (f*SLOTS + i) & 255);
      chk("R3 valid", out_valid, 1);
      chk("R3 data", out_data, 16'hA000 + ((f*SLOTS + i) & 255));
      chk("R3 no collide", collide, 0);
    end
  endtask

  task automatic t_sparse();
    int f;
    align();
    f = now / SLOTS + 1;
    step(1'b1, 16'hB003, f*SLOTS + 3, 1'b0, 0);
    step(1'b1, 16'hB001, f*SLOTS + 1, 1'b0, 0);
    idle(); idle();
    idle();
    chk("R9 slot0 freed", out_valid, 0);
    chk("R4 slot0 data", out_data, 0);
    idle();
    chk("R3 slot1", out_data, 16'hB001);
    idle();
    chk("R4 slot2 idle", out_valid, 0);
    chk("R9 slot2 data", out_data, 0);
    idle();
    chk("R3 slot3", out_data, 16'hB003);
  endtask

  task automatic t_bypass();
    int f;
    align();
    f = now / SLOTS + 1;
    step(1'b1, 16'hC002, f*SLOTS + 2, 1'b0, 0);
    step(1'b1, 16'hC001, f*SLOTS + 1, 1'b0, 0);
    idle(); idle();
    step(1'b0, 0, 0, 1'b1, 16'hD000);
    chk("R5 bypass valid", out_valid, 1);
    chk("R5 bypass data", out_data, 16'hD000);
    chk("R5 no collide", collide, 0);
    idle();
    chk("R3 stored slot1", out_data, 16'hC001);
    step(1'b0, 0, 0, 1'b1, 16'hD002);
    chk("R6 stored wins", out_data, 16'hC002);
    chk("R6 collide", collide, 1);
    step(1'b0, 0, 0, 1'b1, 16'hD003);
    chk("R5 bypass slot3", out_data, 16'hD003);
    chk("R6 collide clears", collide, 0);
  endtask

  task automatic t_drop();
    int f;
    align();
    f = now / SLOTS + 1;
    step(1'b1, 16'hE0E0, now, 1'b0, 0);
    chk("R7 current frame dropped", drop, 1);
    chk("R7 not emitted", out_valid, 0);
    step(1'b1, 16'hE1E1, (f+1)*SLOTS, 1'b0, 0);
    chk("R7 far frame dropped", drop, 1);
    step(1'b1, 16'hE202, f*SLOTS + 2, 1'b0, 0);
    chk("R8 first accepted", drop, 0);
    step(1'b1, 16'hE303, f*SLOTS + 2, 1'b0, 0);
    chk("R8 duplicate dropped", drop, 1);
    idle();
    chk("R7 drop is one cycle", drop, 0);
    chk("R4 slot0 idle", out_valid, 0);
    idle(); idle();
    chk("R8 first kept", out_data, 16'hE202);
    idle(); idle();
    chk("R7 far cell never emitted", out_valid, 0);
  endtask

  task automatic t_wrap();
    while (now % 256 != 252) idle();
    for (int i = 0; i < SLOTS; i++) begin
      step(1'b1, 16'hF000 + i, i, 1'b0, 0);
      chk("R3 wrap accepted", drop, 0);
    end
    for (int i = 0; i < SLOTS; i++) begin
      idle();
      chk("R2 wrap slot", out_slot, i);
      chk("R3 wrap data", out_data, 16'hF000 + i);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_reverse();
    t_sparse();
    t_bypass();
    t_drop();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule